// File: doc/BRIEF.md
# Programmable Horizontal Sync Generator

This block produces the horizontal sync output of a video decoder. A pixel-rate position counter is advanced on every cycle in which the pixel clock enable is high. It returns to zero whenever an upstream detector reports a horizontal sync event, so the output follows the incoming line timing. If no sync event arrives, the counter wraps by itself at a programmed nominal line length. The output then keeps running at the video line rate while no source is connected.

The output pulse is high between two programmable positions in the line, counted from the line reference in output-sample steps. The two 10-bit positions may describe a window that wraps through the end of the line. The line length and both positions are copied into working registers only at a line boundary, which is a restart or a wrap. Software can therefore rewrite them at any moment without cutting or doubling a pulse.

Top module: `line_sync_gen`

## Requirements
- R1: While reset is low and after its release, the output is low. The working start and end positions reset to 0, so no pulse appears until a line boundary loads new settings.
- R2: A sync strobe taken with the pixel enable high, while the position is not 0, returns the position to 0. On the cycle after that edge the output shows position 0.
- R3: With no strobe, the position counts 0 to L-1 and then wraps to 0, where L is the working line length. A window at position 0 therefore repeats every L enabled cycles.
- R4: When start < end, the output is high exactly for the positions p with start <= p < end.
- R5: When start equals end, the output stays low for the whole line.
- R6: When end < start, the output is high for p >= start and for p < end, so the pulse runs through the line end.
- R7: A strobe taken while the position is already 0 is ignored. The position moves on to 1, and no second pulse or zero-length line results.
- R8: New line length, start and end values take effect only at the next restart or wrap. The line in progress keeps its old pulse.
- R9: While the pixel enable is low, the position and the output hold their values.
- R10: A strobe taken while the pixel enable is low has no effect on the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Output-sample-rate clock enable |
| syncStrobe | input | 1 | Detected horizontal sync event, one enabled cycle |
| lineLen | input | 12 | Nominal line length in samples (free-run period) |
| startPos | input | 10 | Pulse start position |
| endPos | input | 10 | Pulse end position (exclusive) |
| hsyncOut | output | 1 | Horizontal sync pulse |

## Verification
Two functions can fall in the same cycle: a sync strobe and the counter already being at position zero, whether just restarted or just wrapped. Another pair is a register rewrite and the line boundary that loads it. The bench places a strobe on the cycle right after a forced restart. It then judges by the gap to the next pulse that the line was neither shortened nor pulsed twice. It also rewrites the window one sample into a line and counts pulse samples separately on the current line and on the next one.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  // Strobes from the control to the datapath, one set per clock
  typedef struct packed {
    logic advance;  // move the position on by one
    logic restart;  // external sync accepted: position to zero
    logic wrap;     // free-running wrap at line end
    logic load;     // line boundary: copy settings into working registers
  } lineCtl_t;
endpackage

// File: rtl/lsg_ctrl.sv
module lsg_ctrl
  import lsg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             pixEn,
  input  logic             syncStrobe,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] lenM1,
  output lineCtl_t         ctl
);
  logic atZero;
  logic atEnd;

  assign atZero = (pos == '0);
  assign atEnd  = (pos >= lenM1);

  always_comb begin
    ctl         = '0;
    ctl.advance = pixEn;
    ctl.restart = pixEn && syncStrobe && !atZero;
    ctl.wrap    = pixEn && !ctl.restart && atEnd;
    ctl.load    = ctl.restart || ctl.wrap;
  end

  // R7: a restart is never issued on a line that has just begun
  always_comb begin
    a_r7_no_restart_at_zero: assert (!(ctl.restart && atZero));
  end
endmodule

// File: rtl/lsg_datapath.sv
module lsg_datapath
  import lsg_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int POS_W   = 10,
  parameter int DEF_LEN = 858
) (
  input  logic             clk,
  input  logic             rstN,
  input  lineCtl_t         ctl,
  input  logic [CNT_W-1:0] lineLen,
  input  logic [POS_W-1:0] startPos,
  input  logic [POS_W-1:0] endPos,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] lenM1,
  output logic             hsync
);
  localparam logic [CNT_W-1:0] RST_LEN = CNT_W'(DEF_LEN);

  logic [CNT_W-1:0] actLen;
  logic [POS_W-1:0] actStart;
  logic [POS_W-1:0] actEnd;
  logic [CNT_W-1:0] startExt;
  logic [CNT_W-1:0] endExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos      <= '0;
      actLen   <= RST_LEN;
      actStart <= '0;
      actEnd   <= '0;
    end else if (ctl.load) begin
      pos      <= '0;
      actLen   <= lineLen;
      actStart <= startPos;
      actEnd   <= endPos;
    end else if (ctl.advance) begin
      pos      <= pos + 1'b1;
    end
  end

  assign lenM1    = (actLen == '0) ? '0 : actLen - 1'b1;
  assign startExt = CNT_W'(actStart);
  assign endExt   = CNT_W'(actEnd);

  always_comb begin
    if (startExt < endExt)       hsync = (pos >= startExt) && (pos < endExt);
    else if (startExt > endExt)  hsync = (pos >= startExt) || (pos < endExt);
    else                         hsync = 1'b0;
  end

  // R3: the position never runs past the working line end
  a_r3_pos_bound: assert property (@(posedge clk) disable iff (!rstN)
    pos <= lenM1);

  // R8: working settings change only on a line boundary
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(actStart) && $stable(actEnd) && $stable(actLen));

  // R5: an empty window never drives the output
  a_r5_empty_window: assert property (@(posedge clk) disable iff (!rstN)
    (actStart == actEnd) |-> !hsync);
endmodule

// File: rtl/line_sync_gen.sv
module line_sync_gen
  import lsg_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int POS_W   = 10,
  parameter int DEF_LEN = 858
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixEn,
  input  logic             syncStrobe,
  input  logic [CNT_W-1:0] lineLen,
  input  logic [POS_W-1:0] startPos,
  input  logic [POS_W-1:0] endPos,
  output logic             hsyncOut
);
  lineCtl_t         ctl;
  logic [CNT_W-1:0] posW;
  logic [CNT_W-1:0] lenM1W;

  lsg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .pixEn      (pixEn),
    .syncStrobe (syncStrobe),
    .pos        (posW),
    .lenM1      (lenM1W),
    .ctl        (ctl)
  );

  lsg_datapath #(.CNT_W(CNT_W), .POS_W(POS_W), .DEF_LEN(DEF_LEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .lineLen  (lineLen),
    .startPos (startPos),
    .endPos   (endPos),
    .pos      (posW),
    .lenM1    (lenM1W),
    .hsync    (hsyncOut)
  );

  // R2: an accepted strobe on a running line restarts it
  a_r2_restart: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && syncStrobe && posW != '0) |=> (posW == '0));

  // R7: a strobe at position zero never holds the line at zero
  a_r7_zero_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && syncStrobe && posW == '0 && lenM1W != '0) |=> (posW == CNT_W'(1)));

  // R9, R10: with the enable low nothing moves
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> $stable(posW) && $stable(hsyncOut));
endmodule

// File: tb/line_sync_gen_bench.sv
`timescale 1ns/1ps
module line_sync_gen_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        pixEn;
  logic        syncStrobe;
  logic [11:0] lineLen;
  logic [9:0]  startPos;
  logic [9:0]  endPos;
  logic        hsyncOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  line_sync_gen u_line_sync_gen (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .syncStrobe(syncStrobe),
    .lineLen(lineLen), .startPos(startPos), .endPos(endPos), .hsyncOut(hsyncOut)
  );

  // {line length, start, end, expected high samples, expected first high (-1 none)}
  localparam int NVEC = 8;
  localparam int VEC [NVEC][5] = '{
    '{20,  3,  8,  5,  3},   // R4 plain window
    '{20,  0,  1,  1,  0},   // R4 single sample at line start
    '{20, 15,  4,  9,  0},   // R6 wrapping window
    '{20,  7,  7,  0, -1},   // R5 empty window
    '{32, 10, 31, 21, 10},   // R4 long window
    '{16,  0, 16, 16,  0},   // R4 window covers whole line
    '{40, 39,  0,  1, 39},   // R6 end at zero
    '{12,  5,  2,  9,  0}    // R6 short line wrap
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int len, input int s, input int e);
    lineLen  = 12'(len);
    startPos = 10'(s);
    endPos   = 10'(e);
  endtask

  // Ends at a negedge where the output shows position 0 of a fresh line
  task automatic syncLine();
    syncStrobe = 1'b1; @(negedge clk);
    syncStrobe = 1'b0; @(negedge clk);
    syncStrobe = 1'b1; @(negedge clk);
    syncStrobe = 1'b0;
  endtask

  // Samples n positions from the current one; returns high count and first high
  task automatic measure(input int n, output int highs, output int first);
    highs = 0;
    first = -1;
    for (int p = 0; p < n; p++) begin
      if (hsyncOut) begin
        if (first < 0) first = p;
        highs++;
      end
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int highs;
    int first;
    int gap;
    bit held;
    rstN = 1'b0; pixEn = 1'b1; syncStrobe = 1'b0;
    setCfg(20, 0, 0);
    repeat (5) @(negedge clk);
    check(hsyncOut == 1'b0, "R1 low in reset", int'(hsyncOut), 0);
    rstN = 1'b1;
    setCfg(20, 2, 9);
    measure(50, highs, first);
    check(highs == 0, "R1 no pulse before first boundary", highs, 0);

    // Table walk: R4, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      setCfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      syncLine();
      measure(VEC[v][0], highs, first);
      check(highs == VEC[v][3], $sformatf("R4/R5/R6 vec%0d count", v), highs, VEC[v][3]);
      check(first == VEC[v][4], $sformatf("R4/R5/R6 vec%0d first", v), first, VEC[v][4]);
    end

    // R3: free-running period equals the line length
    setCfg(10, 0, 1);
    syncLine();
    held = 1'b1;
    highs = 0;
    for (int t = 0; t < 30; t++) begin
      if (hsyncOut) begin
        highs++;
        if (t % 10 != 0) held = 1'b0;
      end
      @(negedge clk);
    end
    check(highs == 3, "R3 pulses in three lines", highs, 3);
    check(held, "R3 pulses on period", int'(held), 1);

    // R9: enable low holds a high output
    syncLine();
    pixEn = 1'b0;
    held = 1'b1;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      if (!hsyncOut) held = 1'b0;
    end
    check(held, "R9 output held high", int'(held), 1);
    pixEn = 1'b1;
    // now at position 0 still; step to position 4
    repeat (4) @(negedge clk);
    pixEn = 1'b0;
    held = 1'b1;
    for (int t = 0; t < 6; t++) begin
      syncStrobe = (t == 2);   // R10 strobe while disabled
      @(negedge clk);
      if (hsyncOut) held = 1'b0;
    end
    syncStrobe = 1'b0;
    check(held, "R9 output held low", int'(held), 1);
    pixEn = 1'b1;
    gap = 0;
    while (!hsyncOut && gap < 40) begin
      @(negedge clk);
      gap++;
    end
    check(gap == 6, "R10 strobe ignored while disabled", gap, 6);

    // R2: mid-line strobe restarts the line
    setCfg(20, 0, 1);
    syncLine();
    repeat (7) @(negedge clk);
    check(hsyncOut == 1'b0, "R2 low mid-line", int'(hsyncOut), 0);
    syncStrobe = 1'b1; @(negedge clk); syncStrobe = 1'b0;
    check(hsyncOut == 1'b1, "R2 restart to position 0", int'(hsyncOut), 1);
    @(negedge clk);
    measure(19, highs, first);
    check(highs == 0, "R2 no extra pulse after restart", highs, 0);
    check(hsyncOut == 1'b1, "R2 free-run after restart", int'(hsyncOut), 1);

    // R7: strobe while position is already zero
    syncLine();
    syncStrobe = 1'b1; @(negedge clk); syncStrobe = 1'b0;
    check(hsyncOut == 1'b0, "R7 moved to position 1", int'(hsyncOut), 0);
    gap = 0;
    while (!hsyncOut && gap < 40) begin
      @(negedge clk);
      gap++;
    end
    check(gap == 19, "R7 full line after zero strobe", gap, 19);

    // R8: mid-line rewrite waits for the boundary
    setCfg(20, 3, 8);
    syncLine();
    @(negedge clk);
    setCfg(20, 10, 12);
    measure(19, highs, first);
    check(highs == 5, "R8 current line keeps old window", highs, 5);
    check(first == 2, "R8 old window start (offset from pos1)", first, 2);
    measure(20, highs, first);
    check(highs == 2, "R8 next line uses new window", highs, 2);
    check(first == 10, "R8 new window start", first, 10);

    finishRun();
  end
endmodule